// File: doc/BRIEF.md
# Framed Serial Word Transmitter with Error Flags

This block sends parallel words as a serial bit stream, one word per frame. A CPU or DMA side writes a word into a single-entry holding buffer. A frame-sync pulse marks the start of a frame. When that pulse is accepted, the buffered word moves into the transmit word register and goes out most significant bit first, one bit per clock. Clock and frame-sync generation are outside the block. The system clock serves as the bit clock.

The block reports three error events as sticky status bits:

- **Underflow.** A frame starts while the buffer is empty. The previous word is sent again, and this repeats on every later frame until new data is written.
- **Sync error.** A frame-sync pulse arrives in the middle of a word. The pulse is ignored and the current word finishes.
- **Overflow.** The buffer is written while it is already full. The new write is discarded.

Each status bit is cleared by writing a one to it. An interrupt output combines the status bits that are enabled.

Top module: `fstx_top`

## Requirements
- R1: After reset, `sdo` is 0, `status` is 0, `irq` is 0, `buf_full` is 0 and `tx_ready` is 1.
- R2: A write (`wr_en` high) to an empty buffer makes `buf_full` 1 and `tx_ready` 0 from the next cycle.
- R3: A valid frame sync with a full buffer loads the buffered word, and the buffer becomes empty on the next cycle. The word appears on `sdo` MSB first. Its MSB is present in the first cycle after the cycle in which `fsync` was sampled, and the following bits follow one per cycle.
- R4: A valid frame sync with an empty buffer sends again the word last loaded (all zeros if no word was ever loaded) and sets `status[0]` (underflow).
- R5: The resend of R4 happens on every valid frame sync until a new word has been written.
- R6: An `fsync` sampled while a word is being sent, except during its last bit, is ignored. The word completes unchanged and `status[1]` (sync error) is set. The ignored pulse sets no underflow.
- R7: A write while `buf_full` is 1 is discarded: the buffered word is kept and `status[2]` (overflow) is set. Buffer fullness is judged on the state before the clock edge.
- R8: Status bits are sticky. A 1 in bit k of `stat_clr` clears only bit k. A new event on the same edge wins over the clear.
- R9: `irq` is 1 exactly when some bit is set in both `status` and `irq_en`.
- R10: Between frames `sdo` is 0 (default `IDLE_HOLD_LAST`=0). With `IDLE_HOLD_LAST`=1 it holds the last bit sent.
- R11: An `fsync` sampled during the last bit of a word is valid. It starts the next word with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe into the holding buffer |
| wr_data | input | WORD_W | Word to write |
| fsync | input | 1 | Frame-sync pulse |
| stat_clr | input | 3 | Write-one-to-clear for status bits |
| irq_en | input | 3 | Interrupt enables per status bit |
| sdo | output | 1 | Serial data out |
| buf_full | output | 1 | Holding buffer holds an unsent word |
| tx_ready | output | 1 | Buffer can take the next word |
| status | output | 3 | Sticky flags: bit0 underflow, bit1 sync error, bit2 overflow |
| irq | output | 1 | Interrupt request |

## Verification
The checker takes for granted that `fsync`, `wr_en` and `stat_clr` are synchronous single-cycle inputs. It also assumes a frame pulse is judged as valid or ignored only from the position within the current word. The stimulus changes every input on the falling edge and keeps each pulse one cycle wide. It also places mid-word and last-bit frame pulses at fixed bit indices, so each case lands in a known position within the word.

// File: rtl/fstx_pkg.sv
package fstx_pkg;
   localparam int EV_UNDER = 0;
   localparam int EV_SYNC  = 1;
   localparam int EV_OVER  = 2;
   localparam int EV_NUM   = 3;
endpackage

// File: rtl/fstx_buffer.sv
module fstx_buffer #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              take,
   output logic [WORD_W-1:0] buf_q,
   output logic              full,
   output logic              ovf_evt
);
   // a write is judged against the fullness before the edge
   assign ovf_evt = wr_en && full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q <= '0;
         full  <= 1'b0;
      end else begin
         if (take)
            full <= 1'b0;
         if (wr_en && !full) begin
            buf_q <= wr_data;
            full  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/fstx_shifter.sv
module fstx_shifter #(
   parameter int WORD_W         = 8,
   parameter bit IDLE_HOLD_LAST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync,
   input  logic              full,
   input  logic [WORD_W-1:0] buf_q,
   output logic              take,
   output logic              sdo,
   output logic              busy,
   output logic              last,
   output logic              und_evt,
   output logic              syn_evt
);
   localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WORD_W - 1);

   logic [WORD_W-1:0] held;
   logic [IDX_W-1:0]  idx;
   logic              frame_ok;
   logic              bit_now;

   assign last     = busy && (idx == '0);
   assign frame_ok = fsync && (!busy || last);
   assign take     = frame_ok && full;
   assign und_evt  = frame_ok && !full;
   assign syn_evt  = fsync && busy && !last;
   assign bit_now  = held[idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= '0;
         idx  <= '0;
         busy <= 1'b0;
      end else if (frame_ok) begin
         if (full)
            held <= buf_q;
         idx  <= IDX_TOP;
         busy <= 1'b1;
      end else if (busy) begin
         if (idx == '0)
            busy <= 1'b0;
         else
            idx <= idx - 1'b1;
      end
   end

   generate
      if (IDLE_HOLD_LAST) begin : g_idle_hold
         logic last_bit;
         always_ff @(posedge clk) begin
            if (!rst_n)
               last_bit <= 1'b0;
            else if (busy)
               last_bit <= bit_now;
         end
         assign sdo = busy ? bit_now : last_bit;
      end else begin : g_idle_zero
         assign sdo = busy ? bit_now : 1'b0;
      end
   endgenerate
endmodule

// File: rtl/fstx_status.sv
module fstx_status #(
   parameter int NUM = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] evt,
   input  logic [NUM-1:0] clr,
   input  logic [NUM-1:0] en,
   output logic [NUM-1:0] status,
   output logic           irq
);
   generate
      for (genvar k = 0; k < NUM; k++) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               flag_q <= 1'b0;
            else if (evt[k])
               flag_q <= 1'b1;
            else if (clr[k])
               flag_q <= 1'b0;
         end
         assign status[k] = flag_q;
      end
   endgenerate

   assign irq = |(status & en);
endmodule

// File: rtl/fstx_top.sv
module fstx_top
   import fstx_pkg::*;
#(
   parameter int WORD_W         = 8,
   parameter bit IDLE_HOLD_LAST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              fsync,
   input  logic [2:0]        stat_clr,
   input  logic [2:0]        irq_en,
   output logic              sdo,
   output logic              buf_full,
   output logic              tx_ready,
   output logic [2:0]        status,
   output logic              irq
);
   generate
      if (WORD_W < 2 || WORD_W > 64) begin : g_bad_width
         $error("fstx_top: WORD_W must lie in 2..64");
      end
   endgenerate

   logic [WORD_W-1:0] buf_q;
   logic              take;
   logic              ovf_evt;
   logic              und_evt;
   logic              syn_evt;
   logic              sh_busy;
   logic              sh_last;
   logic [EV_NUM-1:0] evt;

   fstx_buffer #(.WORD_W(WORD_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .buf_q   (buf_q),
      .full    (buf_full),
      .ovf_evt (ovf_evt)
   );

   fstx_shifter #(.WORD_W(WORD_W), .IDLE_HOLD_LAST(IDLE_HOLD_LAST)) u_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .fsync   (fsync),
      .full    (buf_full),
      .buf_q   (buf_q),
      .take    (take),
      .sdo     (sdo),
      .busy    (sh_busy),
      .last    (sh_last),
      .und_evt (und_evt),
      .syn_evt (syn_evt)
   );

   always_comb begin
      evt           = '0;
      evt[EV_UNDER] = und_evt;
      evt[EV_SYNC]  = syn_evt;
      evt[EV_OVER]  = ovf_evt;
   end

   fstx_status #(.NUM(EV_NUM)) u_st (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt),
      .clr    (stat_clr),
      .en     (irq_en),
      .status (status),
      .irq    (irq)
   );

   assign tx_ready = !buf_full;
endmodule

// File: rtl/fstx_chk.sv
module fstx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fsync,
   input logic       wr_en,
   input logic [2:0] stat_clr,
   input logic       buf_full,
   input logic [2:0] status,
   input logic       irq,
   input logic       busy,
   input logic       last
);
   assert_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && !buf_full && (!busy || last)) |=> status[0]);

   assert_sync_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && busy && !last) |=> (status[1] && busy));

   assert_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && buf_full && !fsync) |=> (status[2] && buf_full));

   assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_full) |-> $past(wr_en));

   assert_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_full) |-> ($past(fsync) && busy));

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & $past(status & ~stat_clr)) == $past(status & ~stat_clr)));

   assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status != 3'b000));
endmodule

bind fstx_top fstx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fsync    (fsync),
   .wr_en    (wr_en),
   .stat_clr (stat_clr),
   .buf_full (buf_full),
   .status   (status),
   .irq      (irq),
   .busy     (sh_busy),
   .last     (sh_last)
);

// File: tb/fstx_top_tb.sv
module fstx_top_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         fsync = 1'b0;
   logic [2:0]   stat_clr = '0;
   logic [2:0]   irq_en = '0;
   logic         sdo, buf_full, tx_ready, irq;
   logic [2:0]   status;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   fstx_top #(.WORD_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .fsync(fsync), .stat_clr(stat_clr), .irq_en(irq_en), .sdo(sdo),
      .buf_full(buf_full), .tx_ready(tx_ready), .status(status), .irq(irq)
   );

   // entry: {write, data, expected word, expected underflow}
   localparam logic [17:0] VEC [0:6] = '{
      {1'b0, 8'h00, 8'h00, 1'b1},
      {1'b1, 8'hA5, 8'hA5, 1'b0},
      {1'b0, 8'h00, 8'hA5, 1'b1},
      {1'b0, 8'h00, 8'hA5, 1'b1},
      {1'b1, 8'h3C, 8'h3C, 1'b0},
      {1'b1, 8'hFF, 8'hFF, 1'b0},
      {1'b1, 8'h01, 8'h01, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_word(input logic [W-1:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_fs();
      fsync = 1'b1;
      @(negedge clk);
      fsync = 1'b0;
   endtask

   task automatic clear_all();
      stat_clr = 3'b111;
      @(negedge clk);
      stat_clr = 3'b000;
   endtask

   // samples W bits; optional fsync or write at bit position i
   task automatic capture(input int fs_at, input int wr_at, input logic [W-1:0] wd,
                          output logic [W-1:0] got);
      for (int i = 0; i < W; i++) begin
         got[W-1-i] = sdo;
         fsync   = (i == fs_at);
         wr_en   = (i == wr_at);
         wr_data = wd;
         @(negedge clk);
      end
      fsync = 1'b0;
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] got;
      logic [W-1:0] got2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 sdo", sdo, 0);
      chk("R1 status", status, 0);
      chk("R1 irq", irq, 0);
      chk("R1 buf_full", buf_full, 0);
      chk("R1 tx_ready", tx_ready, 1);

      // table: normal sends, R4 underflow resend and R5 repeat
      for (int v = 0; v < 7; v++) begin
         clear_all();
         if (VEC[v][17]) write_word(VEC[v][16:9]);
         pulse_fs();
         capture(-1, -1, '0, got);
         chk(VEC[v][0] ? "R4/R5 resend word" : "R3 sent word", got, VEC[v][8:1]);
         chk("R4 underflow flag", status[0], VEC[v][0]);
         chk("R3 buffer drained", tx_ready, 1);
         chk("R10 idle level", sdo, 0);
      end

      // R2 and R7: fill, then overflow write discarded
      clear_all();
      write_word(8'h5A);
      chk("R2 buf_full", buf_full, 1);
      chk("R2 tx_ready", tx_ready, 0);
      write_word(8'h77);
      chk("R7 overflow flag", status[2], 1);
      chk("R7 still full", buf_full, 1);
      pulse_fs();
      capture(-1, -1, '0, got);
      chk("R7 kept first word", got, 8'h5A);

      // R6: mid-word frame sync ignored
      clear_all();
      write_word(8'hC3);
      pulse_fs();
      capture(2, -1, '0, got);
      chk("R6 word intact", got, 8'hC3);
      chk("R6 sync error flag", status[1], 1);
      chk("R6 no underflow", status[0], 0);
      chk("R6 no restart", sdo, 0);

      // R11: frame sync in last bit starts next word at once
      clear_all();
      write_word(8'h96);
      pulse_fs();
      capture(W-1, 1, 8'h4B, got);
      capture(-1, -1, '0, got2);
      chk("R11 first word", got, 8'h96);
      chk("R11 second word", got2, 8'h4B);
      chk("R11 no sync error", status[1], 0);
      chk("R11 no underflow", status[0], 0);

      // R8: set wins over clear on same edge, partial clear
      clear_all();
      write_word(8'h11);
      wr_en = 1'b1; wr_data = 8'h22; stat_clr = 3'b100;
      @(negedge clk);
      wr_en = 1'b0; stat_clr = 3'b000;
      chk("R8 set beats clear", status[2], 1);
      pulse_fs();
      capture(-1, -1, '0, got);
      chk("R7 word 11 kept", got, 8'h11);
      pulse_fs();
      capture(-1, -1, '0, got);
      chk("R8 two flags set", status, 3'b101);
      stat_clr = 3'b100;
      @(negedge clk);
      stat_clr = 3'b000;
      chk("R8 partial clear", status, 3'b001);
      @(negedge clk);
      chk("R8 sticky", status, 3'b001);

      // R9 interrupt masking
      irq_en = 3'b000;
      @(negedge clk);
      chk("R9 masked", irq, 0);
      irq_en = 3'b001;
      @(negedge clk);
      chk("R9 enabled", irq, 1);
      irq_en = 3'b110;
      @(negedge clk);
      chk("R9 other enables", irq, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule